// File: doc/BRIEF.md
# Delayed-Output Noise Shift Register

This block produces the noise bit of one programmable sound generator channel. Its core is a right-shifting Fibonacci shift register. Each step sends a new feedback bit into the top position, and bit 0 drives the output. The parameters set three things: the effective register length, which taps feed the XOR, and whether the output is inverted.

A number of pure delay stages can sit under the effective register. These stages shift along with it but never feed back. As a result, a register wider than the effective length acts as a shorter-period sequence whose output comes some steps late. A 15-bit sequence with two delay stages is one example: it shows up as a 17-bit register tapped at bits 2 and 3.

An external frequency divider pulses `shift_en` to advance the register. `white_sel` selects between two kinds of noise. White noise takes the XOR of the taps. Periodic noise recirculates only the lowest effective bit. `reseed` restarts the sequence whenever the noise setting is rewritten.

All pins are plain control and status pins. No stream interface exists and there is no back-pressure. `noise_out` is valid in every cycle and only changes on an edge where the register steps or reloads.

Top module: `noise_lfsr`

## Requirements
- R1: Reset and `reseed` each load the register with only its topmost bit set. Directly afterwards, `noise_out` equals `OUT_INVERT`.
- R2: In a cycle where `shift_en` and `reseed` are both low, the register holds its value. `noise_out` is unchanged, and after stepping resumes the sequence continues as if no pause had happened.
- R3: On an enabled step the register shifts right by one bit, and the feedback bit enters the top position. With DELAY_STAGES = 0, the output follows the reference recurrence bit for bit.
- R4: After a reseed, the seeded bit first reaches `noise_out` (not inverted: 1; inverted: 0) after exactly LFSR_LEN + DELAY_STAGES − 1 enabled steps.
- R5: In white mode, `noise_out` repeats with period exactly 2^LFSR_LEN − 1 once the delay stages hold sequence bits.
- R6: The delay stages take no part in the feedback. The output equals the plain LFSR_LEN-bit sequence delayed by DELAY_STAGES steps, and shows zeros (before inversion) during the first DELAY_STAGES steps after a seed.
- R7: In periodic mode (`white_sel` = 0), the feedback is the register bit at position DELAY_STAGES alone. After a reseed, the seeded bit reaches the output at step LFSR_LEN + DELAY_STAGES − 1 and again every LFSR_LEN steps after that.
- R8: `OUT_INVERT` = 1 inverts `noise_out` relative to register bit 0.
- R9: If `reseed` and `shift_en` are high in the same cycle, the reseed wins and no step is taken.
- R10: Over one white-noise period, the output bit (before inversion) is 1 exactly 2^(LFSR_LEN−1) times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the seed |
| shift_en | input | 1 | Step strobe from the external frequency divider |
| white_sel | input | 1 | 1 = white noise (XOR of taps), 0 = periodic noise |
| reseed | input | 1 | Synchronous reload of the seed; takes priority over stepping |
| noise_out | output | 1 | Noise bit (register bit 0, optionally inverted) |

## Verification
Every result is due one cycle after its stimulus. A step or reseed sampled on a rising edge shows on `noise_out` just after that edge, because the output is register bit 0 with only an optional inverter behind it. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Each sample therefore belongs to exactly one step.

Delay-stage effects are checked by step count rather than by wall time. Examples are the first seeded bit at step LEN+DELAY−1, and the delayed copy of the effective sequence.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

  typedef enum logic {
    NOISE_PERIODIC = 1'b0,
    NOISE_WHITE    = 1'b1
  } noise_mode_e;

endpackage

// File: rtl/noise_fb.sv
module noise_fb
  import noise_lfsr_pkg::*;
#(
  parameter int              REG_W    = 17,
  parameter int              DELAY    = 2,
  parameter logic [REG_W-1:0] TAPS_ABS = 17'h0000C
) (
  input  logic [REG_W-1:0] state,
  input  noise_mode_e      mode,
  output logic             fb
);

  logic white_fb;
  logic periodic_fb;

  assign white_fb    = ^(state & TAPS_ABS);
  assign periodic_fb = state[DELAY];

  always_comb begin
    if (mode == NOISE_WHITE) fb = white_fb;
    else                     fb = periodic_fb;
  end

endmodule

// File: rtl/noise_shreg.sv
module noise_shreg #(
  parameter int REG_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reseed,
  input  logic             shift_en,
  input  logic             fb_in,
  output logic [REG_W-1:0] state
);

  localparam logic [REG_W-1:0] SEED = {1'b1, {(REG_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= SEED;
    else if (reseed)   state <= SEED;
    else if (shift_en) state <= {fb_in, state[REG_W-1:1]};
  end

  // R1, R9: a reseed always wins
  p_reseed_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> state == SEED);

  // R2: no strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !shift_en) |=> $stable(state));

  // R3: low bits move down one place on a step
  p_shift_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !reseed) |=> state[REG_W-2:0] == $past(state[REG_W-1:1]));

  // R3: top bit takes the feedback produced by the feedback logic
  p_insert_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !reseed) |=> state[REG_W-1] == $past(fb_in));

endmodule

// File: rtl/noise_out_stage.sv
module noise_out_stage #(
  parameter bit INVERT = 1'b0
) (
  input  logic lsb,
  output logic out_bit
);

  generate
    if (INVERT) begin : g_inv
      assign out_bit = ~lsb;
    end else begin : g_pass
      assign out_bit = lsb;
    end
  endgenerate

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import noise_lfsr_pkg::*;
#(
  parameter int                  LFSR_LEN     = 15,
  parameter int                  DELAY_STAGES = 2,
  parameter logic [LFSR_LEN-1:0] EFF_TAPS     = 15'h0003,
  parameter bit                  OUT_INVERT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic white_sel,
  input  logic reseed,
  output logic noise_out
);

  localparam int               REG_W    = LFSR_LEN + DELAY_STAGES;
  localparam logic [REG_W-1:0] TAPS_ABS = REG_W'(EFF_TAPS) << DELAY_STAGES;

  noise_mode_e      mode;
  logic [REG_W-1:0] state;
  logic             fb;

  assign mode = white_sel ? NOISE_WHITE : NOISE_PERIODIC;

  noise_fb #(
    .REG_W    (REG_W),
    .DELAY    (DELAY_STAGES),
    .TAPS_ABS (TAPS_ABS)
  ) u_fb (
    .state (state),
    .mode  (mode),
    .fb    (fb)
  );

  noise_shreg #(
    .REG_W (REG_W)
  ) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .reseed   (reseed),
    .shift_en (shift_en),
    .fb_in    (fb),
    .state    (state)
  );

  noise_out_stage #(
    .INVERT (OUT_INVERT)
  ) u_out (
    .lsb     (state[0]),
    .out_bit (noise_out)
  );

  // R5: the effective section never collapses to all zeros
  p_effective_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state[REG_W-1:DELAY_STAGES] != '0);

  // R7: periodic mode only rotates the effective section
  p_periodic_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !reseed && !white_sel) |=>
      $countones(state[REG_W-1:DELAY_STAGES]) ==
      $countones($past(state[REG_W-1:DELAY_STAGES])));

endmodule

// File: tb/noise_lfsr_bench.sv
`timescale 1ns/1ps
module noise_lfsr_bench;

  localparam int HLEN = 131120;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, shift_en, white_sel, reseed;
  logic out_a, out_b;

  // A: 15-bit effective, 2 delay stages, taps 0,1, plain output
  noise_lfsr u_noise_lfsr (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .white_sel(white_sel), .reseed(reseed), .noise_out(out_a));

  // B: 16-bit effective, no delay, taps 0,4,13,15, inverted output
  noise_lfsr #(
    .LFSR_LEN(16), .DELAY_STAGES(0), .EFF_TAPS(16'hA011), .OUT_INVERT(1'b1)
  ) u_noise_lfsr_w16 (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .white_sel(white_sel), .reseed(reseed), .noise_out(out_b));

  int checks = 0;
  int errors = 0;

  // reference: effective sequences only, delay kept as a separate pipeline
  logic [15:0] ea, eb;
  logic        da1, da2;
  bit hist_a [0:HLEN-1];
  bit hist_b [0:HLEN-1];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic model_seed();
    ea = 16'h4000; eb = 16'h8000; da1 = 1'b0; da2 = 1'b0;
  endtask

  task automatic model_advance(input bit wh);
    logic fa, fbb;
    fa  = wh ? (ea[0] ^ ea[1]) : ea[0];
    fbb = wh ? (eb[0] ^ eb[4] ^ eb[13] ^ eb[15]) : eb[0];
    da2 = da1;
    da1 = ea[0];
    ea  = {1'b0, fa, ea[14:1]};
    eb  = {fbb, eb[15:1]};
  endtask

  function automatic bit exp_a(); return da2;     endfunction
  function automatic bit exp_b(); return ~eb[0];  endfunction

  task automatic do_step(input bit en, input bit rs, input bit wh);
    @(negedge clk);
    shift_en = en; reseed = rs; white_sel = wh;
    @(posedge clk);
    #1;
    if (rs) model_seed();
    else if (en) model_advance(wh);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int mm_a, mm_b, first_a, first_b, ones_a, zeros_b;
    bit prev_a, prev_b;
    rst_n = 1'b0; shift_en = 1'b0; white_sel = 1'b1; reseed = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_seed();
    #1;
    check(out_a == 1'b0, "R1 reset A", out_a, 0);
    check(out_b == 1'b1, "R1 R8 reset B", out_b, 1);

    // run, pause, resume (R2)
    mm_a = 0; mm_b = 0;
    for (int k = 0; k < 25; k++) begin
      do_step(1, 0, 1);
      if (out_a !== exp_a()) mm_a++;
      if (out_b !== exp_b()) mm_b++;
    end
    prev_a = out_a; prev_b = out_b;
    for (int k = 0; k < 6; k++) begin
      do_step(0, 0, 1);
      if (out_a !== prev_a || out_b !== prev_b) mm_a++;
    end
    check(mm_a == 0, "R2 hold stable", mm_a, 0);
    for (int k = 0; k < 30; k++) begin
      do_step(1, 0, 1);
      if (out_a !== exp_a()) mm_b++;
      if (out_b !== exp_b()) mm_b++;
    end
    check(mm_b == 0, "R2 resume in sequence", mm_b, 0);

    // reseed together with step (R9), then first-arrival timing (R4)
    do_step(1, 1, 1);
    check(out_a == 1'b0, "R9 reseed wins A", out_a, 0);
    check(out_b == 1'b1, "R9 reseed wins B", out_b, 1);
    first_a = -1; first_b = -1;
    for (int k = 1; k <= 20; k++) begin
      do_step(1, 0, 1);
      if (first_a < 0 && out_a == 1'b1) first_a = k;
      if (first_b < 0 && out_b == 1'b0) first_b = k;
    end
    check(first_a == 16, "R4 first bit A", first_a, 16);
    check(first_b == 15, "R4 first bit B", first_b, 15);

    // long white run against the reference (R3, R6)
    do_step(0, 1, 1);
    mm_a = 0; mm_b = 0;
    hist_a[0] = out_a; hist_b[0] = out_b;
    for (int k = 1; k < HLEN; k++) begin
      do_step(1, 0, 1);
      hist_a[k] = out_a; hist_b[k] = out_b;
      if (out_a !== exp_a()) mm_a++;
      if (out_b !== exp_b()) mm_b++;
    end
    check(mm_a == 0, "R6 delayed 15-bit sequence A", mm_a, 0);
    check(mm_b == 0, "R3 sequence B", mm_b, 0);

    // period and balance (R5, R10)
    mm_a = 0; mm_b = 0; ones_a = 0; zeros_b = 0;
    for (int k = 17; k < 17 + 32767; k++) begin
      if (hist_a[k] != hist_a[k + 32767]) mm_a++;
      if (hist_a[k]) ones_a++;
    end
    for (int k = 16; k < 16 + 65535; k++) begin
      if (hist_b[k] != hist_b[k + 65535]) mm_b++;
      if (!hist_b[k]) zeros_b++;
    end
    check(mm_a == 0, "R5 period 32767 A", mm_a, 0);
    check(mm_b == 0, "R5 period 65535 B", mm_b, 0);
    check(ones_a == 16384, "R10 ones per period A", ones_a, 16384);
    check(zeros_b == 32768, "R10 R8 ones per period B", zeros_b, 32768);

    // periodic mode (R7): arithmetic expectation
    do_step(0, 1, 0);
    mm_a = 0; mm_b = 0;
    for (int k = 1; k <= 70; k++) begin
      bit ea_exp, eb_exp;
      do_step(1, 0, 0);
      ea_exp = (k >= 16) && ((k - 16) % 15 == 0);
      eb_exp = !((k >= 15) && ((k - 15) % 16 == 0));
      if (out_a !== ea_exp) mm_a++;
      if (out_b !== eb_exp) mm_b++;
    end
    check(mm_a == 0, "R7 periodic A", mm_a, 0);
    check(mm_b == 0, "R7 periodic B", mm_b, 0);

    finish_run();
  end

endmodule